// File: doc/BRIEF.md
# Virtual ROM cache controller

This block sits between a small soft CPU and its on-chip memory and lets a large read-only region, kept in external SPI flash, appear to software as a window of ordinary addresses. It watches the data port and the instruction-fetch port at the same time. An address below the window, or above it, goes through to on-chip memory unchanged. An address inside the window is looked up in a small direct-mapped tag store. When the line is resident, the address is rewritten to a slot in an 8 KB cache area of block RAM in the same cycle.

A window access whose line is not resident does not complete. A store into the window does not complete either. In both cases the block flags a fault on that port and raises a sticky exception line to the CPU. The handler reads the faulting address and its cause from a small register file. It copies the flash line into the cache area and records the line with a fill write. It then acknowledges, and the CPU retries the faulting instruction. A single write invalidates every line, for example after the flash contents change.

Top module: `vrom_cache`

## Requirements
- R1: An access with its request high to an address outside the window 0x10000..0x17FFF completes (ok high, fault low) with the physical address equal to the low 14 bits of the address, for loads, stores and fetches alike.
- R2: The window is direct-mapped in 256-byte lines: for window offset o = addr - 0x10000, the line index is o[12:8] (32 lines) and the tag is o[14:13]. A line hits only when it is valid and its stored tag equals the access tag.
- R3: A data load that hits completes in the same cycle, with the physical address 0x2000 + index*256 + o[7:0]. No port ever shows ok and fault together.
- R4: An instruction fetch that hits is translated the same way as a load, in the same cycle.
- R5: A data load that misses shows fault high and ok low in that cycle. If no exception is pending, the exception output rises on the next cycle. Register 0 then reads bit 31 = pending, bits 25:24 = cause (1 = load miss) and bits 16:0 = the faulting address. All other bits read 0, and every other register address reads 0.
- R6: A fetch miss behaves as in R5 with cause 2.
- R7: A store anywhere in the window faults with cause 3, even when the line is resident, and leaves the valid bits and tags unchanged.
- R8: The exception output stays high until a write to register 3. While it is pending, further faults are still flagged on their ports but do not change the captured cause or address. A fault in the acknowledging cycle is not captured.
- R9: A write to register 1 with a window address in data bits 16:0 marks that address's line valid with its tag. The line hits from the next cycle on.
- R10: A write to register 2 clears every valid bit from the next cycle on.
- R11: After reset no line is valid, the exception output is low and register 0 reads 0.
- R12: When the data and fetch ports fault in the same cycle with no exception pending, the data fault is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a store |
| d_addr | input | 17 | Data byte address from the CPU |
| d_ok | output | 1 | Data access may complete on d_paddr |
| d_fault | output | 1 | Data access faulted this cycle |
| d_paddr | output | 14 | Physical on-chip data address |
| i_req | input | 1 | Instruction fetch request |
| i_addr | input | 17 | Program counter |
| i_ok | output | 1 | Fetch may complete on i_paddr |
| i_fault | output | 1 | Fetch faulted this cycle |
| i_paddr | output | 14 | Physical on-chip fetch address |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | 4 | Register number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| exc | output | 1 | Pending exception to the CPU |

## Verification
The checker assumes that the request, store and register strobes are known 0 or 1 after reset. It also assumes that the CPU issues at most one register operation per cycle, so a fill and a flush never coincide. Its ok/fault and pass-through properties are therefore only meaningful for clean combinational inputs. The bench drives every input at the falling edge and samples one nanosecond later. It walks through pass-through, miss, fill, hit, store and simultaneous-fault cases, and then runs a few hundred cycles of mixed traffic. That traffic is drawn from a handful of lines and tags so that hits, tag conflicts, acknowledges and flushes all recur.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_LOAD  = 2'd1,
        FC_FETCH = 2'd2,
        FC_STORE = 2'd3
    } fault_code_e;

    localparam logic [3:0] RA_FAULT = 4'd0;
    localparam logic [3:0] RA_FILL  = 4'd1;
    localparam logic [3:0] RA_FLUSH = 4'd2;
    localparam logic [3:0] RA_ACK   = 4'd3;
endpackage

// File: rtl/vrc_xlate.sv
// Window decode, tag compare and address rewrite for one CPU port.
module vrc_xlate
    import vrc_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int          PHYS_W     = 14,
    parameter int          LINE_BITS  = 8,
    parameter int          LINES      = 32,
    parameter int          IDX_W      = 5,
    parameter int          TAG_W      = 2,
    parameter logic [31:0] WIN_BASE   = 32'h0001_0000,
    parameter logic [31:0] WIN_SIZE   = 32'h0000_8000,
    parameter logic [31:0] CACHE_BASE = 32'h0000_2000,
    parameter bit          IS_FETCH   = 1'b0
) (
    input  logic                        req,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [LINES-1:0]            valid,
    output logic                        ok,
    output logic                        fault,
    output logic [PHYS_W-1:0]           paddr,
    output fault_code_e                 code
);
    localparam int OFS_W = $clog2(WIN_SIZE);

    logic [31:0]          a32;
    logic                 in_win;
    logic [OFS_W-1:0]     rel;
    logic [IDX_W-1:0]     idx;
    logic [TAG_W-1:0]     tag;
    logic [LINE_BITS-1:0] off;
    logic                 hit;

    always_comb begin
        a32    = 32'(addr);
        in_win = (a32 >= WIN_BASE) && (a32 < (WIN_BASE + WIN_SIZE));
        rel    = OFS_W'(a32 - WIN_BASE);
        off    = rel[LINE_BITS-1:0];
        idx    = rel[LINE_BITS +: IDX_W];
        tag    = rel[LINE_BITS+IDX_W +: TAG_W];
        hit    = valid[idx] && (tags[idx] == tag);

        if (in_win) begin
            paddr = PHYS_W'(CACHE_BASE) + PHYS_W'({idx, off});
        end else begin
            paddr = a32[PHYS_W-1:0];
        end

        ok    = req && (!in_win || (hit && !we));
        fault = req && in_win && (!hit || we);

        if (we) begin
            code = FC_STORE;
        end else if (IS_FETCH) begin
            code = FC_FETCH;
        end else begin
            code = FC_LOAD;
        end
    end
endmodule

// File: rtl/vrc_tags.sv
// Direct-mapped tag and valid store.
module vrc_tags #(
    parameter int LINES = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [IDX_W-1:0]            set_idx,
    input  logic [TAG_W-1:0]            set_tag,
    input  logic                        flush,
    output logic [LINES-1:0][TAG_W-1:0] tags,
    output logic [LINES-1:0]            valid
);
    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tag_st_t;

    tag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end
        for (int k = 0; k < LINES; k++) begin
            if (set_en && (set_idx == IDX_W'(k))) begin
                st_d.valid[k] = 1'b1;
                st_d.tag[k]   = set_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tags  = st_q.tag;
    assign valid = st_q.valid;
endmodule

// File: rtl/vrc_fault.sv
// Fault capture, exception line and handler register file.
module vrc_fault
    import vrc_pkg::*;
#(
    parameter int          ADDR_W    = 17,
    parameter int          LINE_BITS = 8,
    parameter int          IDX_W     = 5,
    parameter int          TAG_W     = 2,
    parameter logic [31:0] WIN_BASE  = 32'h0001_0000,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              d_fault,
    input  fault_code_e       d_code,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              i_fault,
    input  fault_code_e       i_code,
    input  logic [ADDR_W-1:0] i_addr,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              flush,
    output logic              exc,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int OFS_W = $clog2(WIN_SIZE);

    typedef struct packed {
        logic              pend;
        fault_code_e       code;
        logic [ADDR_W-1:0] addr;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic             wr, ack;
    logic [OFS_W-1:0] fill_rel;

    always_comb begin
        wr       = reg_sel && reg_we;
        ack      = wr && (reg_addr == RA_ACK);
        flush    = wr && (reg_addr == RA_FLUSH);
        fill_en  = wr && (reg_addr == RA_FILL);
        fill_rel = OFS_W'(reg_wdata - WIN_BASE);
        fill_idx = fill_rel[LINE_BITS +: IDX_W];
        fill_tag = fill_rel[LINE_BITS+IDX_W +: TAG_W];
    end

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            if (ack) begin
                st_d.pend = 1'b0;
            end
        end else if (d_fault) begin
            st_d.pend = 1'b1;
            st_d.code = d_code;
            st_d.addr = d_addr;
        end else if (i_fault) begin
            st_d.pend = 1'b1;
            st_d.code = i_code;
            st_d.addr = i_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_FAULT) begin
            reg_rdata[31]         = st_q.pend;
            reg_rdata[25:24]      = st_q.code;
            reg_rdata[ADDR_W-1:0] = st_q.addr;
        end
    end

    assign exc        = st_q.pend;
    assign fault_addr = st_q.addr;
endmodule

// File: rtl/vrom_cache.sv
module vrom_cache
    import vrc_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int          PHYS_W     = 14,
    parameter int          LINE_BITS  = 8,
    parameter int          LINES      = 32,
    parameter logic [31:0] WIN_BASE   = 32'h0001_0000,
    parameter logic [31:0] WIN_SIZE   = 32'h0000_8000,
    parameter logic [31:0] CACHE_BASE = 32'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_req,
    input  logic              d_we,
    input  logic [ADDR_W-1:0] d_addr,
    output logic              d_ok,
    output logic              d_fault,
    output logic [PHYS_W-1:0] d_paddr,
    input  logic              i_req,
    input  logic [ADDR_W-1:0] i_addr,
    output logic              i_ok,
    output logic              i_fault,
    output logic [PHYS_W-1:0] i_paddr,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              exc
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFS_W = $clog2(WIN_SIZE);
    localparam int TAG_W = OFS_W - LINE_BITS - IDX_W;

    logic [LINES-1:0][TAG_W-1:0] line_tag;
    logic [LINES-1:0]            line_valid;
    fault_code_e                 d_code, i_code;
    logic                        fill_en, flush;
    logic [IDX_W-1:0]            fill_idx;
    logic [TAG_W-1:0]            fill_tag;
    logic [ADDR_W-1:0]           fault_addr;

    vrc_xlate #(
        .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .LINE_BITS(LINE_BITS), .LINES(LINES),
        .IDX_W(IDX_W), .TAG_W(TAG_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
        .CACHE_BASE(CACHE_BASE), .IS_FETCH(1'b0)
    ) u_dport (
        .req(d_req), .we(d_we), .addr(d_addr), .tags(line_tag), .valid(line_valid),
        .ok(d_ok), .fault(d_fault), .paddr(d_paddr), .code(d_code)
    );

    vrc_xlate #(
        .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .LINE_BITS(LINE_BITS), .LINES(LINES),
        .IDX_W(IDX_W), .TAG_W(TAG_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
        .CACHE_BASE(CACHE_BASE), .IS_FETCH(1'b1)
    ) u_iport (
        .req(i_req), .we(1'b0), .addr(i_addr), .tags(line_tag), .valid(line_valid),
        .ok(i_ok), .fault(i_fault), .paddr(i_paddr), .code(i_code)
    );

    vrc_tags #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .set_en(fill_en), .set_idx(fill_idx),
        .set_tag(fill_tag), .flush(flush), .tags(line_tag), .valid(line_valid)
    );

    vrc_fault #(
        .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
    ) u_fault (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .d_fault(d_fault), .d_code(d_code), .d_addr(d_addr),
        .i_fault(i_fault), .i_code(i_code), .i_addr(i_addr),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
        .flush(flush), .exc(exc), .fault_addr(fault_addr)
    );
endmodule

// File: rtl/vrom_cache_chk.sv
module vrom_cache_chk #(
    parameter int          ADDR_W   = 17,
    parameter int          PHYS_W   = 14,
    parameter int          LINES    = 32,
    parameter logic [31:0] WIN_BASE = 32'h0001_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0000_8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              d_req,
    input logic              d_we,
    input logic [ADDR_W-1:0] d_addr,
    input logic              d_ok,
    input logic              d_fault,
    input logic [PHYS_W-1:0] d_paddr,
    input logic              i_ok,
    input logic              i_fault,
    input logic              exc,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [LINES-1:0]  line_valid,
    input logic [ADDR_W-1:0] fault_addr
);
    logic ack_wr, flush_wr, any_wr, d_in_win;
    assign any_wr   = reg_sel && reg_we;
    assign ack_wr   = any_wr && (reg_addr == 4'd3);
    assign flush_wr = any_wr && (reg_addr == 4'd2);
    assign d_in_win = (32'(d_addr) >= WIN_BASE) && (32'(d_addr) < (WIN_BASE + WIN_SIZE));

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && !d_in_win) |-> (d_ok && !d_fault && (d_paddr == d_addr[PHYS_W-1:0])));

    assert_ok_fault_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_ok && d_fault) && !(i_ok && i_fault));

    assert_fault_raises_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_fault || i_fault) && !exc) |=> exc);

    assert_store_keeps_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_we && d_in_win && !any_wr) |=> $stable(line_valid));

    assert_exc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc && !ack_wr) |=> (exc && $stable(fault_addr)));

    assert_ack_drops_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc && ack_wr) |=> !exc);

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (line_valid == '0));
endmodule

bind vrom_cache vrom_cache_chk #(
    .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .LINES(LINES),
    .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
    .d_ok(d_ok), .d_fault(d_fault), .d_paddr(d_paddr), .i_ok(i_ok),
    .i_fault(i_fault), .exc(exc), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .line_valid(line_valid), .fault_addr(fault_addr)
);

// File: tb/vrom_cache_test.sv
`timescale 1ns/1ps
module vrom_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_req = 1'b0, d_we = 1'b0;
    logic [16:0] d_addr = '0;
    logic        d_ok, d_fault;
    logic [13:0] d_paddr;
    logic        i_req = 1'b0;
    logic [16:0] i_addr = '0;
    logic        i_ok, i_fault;
    logic [13:0] i_paddr;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exc;

    always #10 clk = ~clk;

    vrom_cache uut (
        .clk(clk), .rst_n(rst_n), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
        .d_ok(d_ok), .d_fault(d_fault), .d_paddr(d_paddr), .i_req(i_req),
        .i_addr(i_addr), .i_ok(i_ok), .i_fault(i_fault), .i_paddr(i_paddr),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc(exc)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_valid[32];
    int m_tag[32];
    bit m_pend;
    int m_code;
    int m_addr;

    task automatic model_port(input bit req, input bit we, input int a, input bit fetch,
                              output bit ok, output bit flt, output int pa, output int code);
        bit win;
        bit hit;
        int r;
        win = (a >= 'h10000) && (a < 'h18000);
        r   = a - 'h10000;
        hit = win && (m_valid[(r >> 8) & 31] != 0) && (m_tag[(r >> 8) & 31] == ((r >> 13) & 3));
        pa  = win ? ('h2000 + (r & 'h1FFF)) : (a & 'h3FFF);
        ok  = req && (!win || (hit && !we));
        flt = req && win && (!hit || we);
        code = we ? 3 : (fetch ? 2 : 1);
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        bit eok, ef, iok, ifl;
        int ep, ip, ec, ic;
        logic [31:0] er;
        bit wr;
        int r;
        #1;
        model_port(d_req, d_we, int'(d_addr), 1'b0, eok, ef, ep, ec);
        model_port(i_req, 1'b0, int'(i_addr), 1'b1, iok, ifl, ip, ic);
        er = '0;
        if (reg_addr == 4'd0) begin
            er[31] = m_pend;
            er[25:24] = 2'(m_code);
            er[16:0] = 17'(m_addr);
        end
        cmp(tag, "d_ok", 32'(d_ok), 32'(eok));
        cmp(tag, "d_fault", 32'(d_fault), 32'(ef));
        cmp(tag, "d_paddr", 32'(d_paddr), 32'(ep));
        cmp(tag, "i_ok", 32'(i_ok), 32'(iok));
        cmp(tag, "i_fault", 32'(i_fault), 32'(ifl));
        cmp(tag, "i_paddr", 32'(i_paddr), 32'(ip));
        cmp(tag, "exc", 32'(exc), 32'(m_pend));
        cmp(tag, "reg_rdata", reg_rdata, er);
        @(posedge clk);
        wr = reg_sel && reg_we;
        if (m_pend) begin
            if (wr && reg_addr == 4'd3) m_pend = 1'b0;
        end else if (ef) begin
            m_pend = 1'b1; m_code = ec; m_addr = int'(d_addr);
        end else if (ifl) begin
            m_pend = 1'b1; m_code = 2; m_addr = int'(i_addr);
        end
        if (wr && reg_addr == 4'd2) begin
            for (int k = 0; k < 32; k++) m_valid[k] = 0;
        end
        if (wr && reg_addr == 4'd1) begin
            r = int'(reg_wdata) - 'h10000;
            m_valid[(r >> 8) & 31] = 1;
            m_tag[(r >> 8) & 31] = (r >> 13) & 3;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        d_req = 1'b0; d_we = 1'b0; i_req = 1'b0;
        reg_sel = 1'b0; reg_we = 1'b0; reg_addr = 4'd0;
    endtask

    task automatic load(input int a, input string tag);
        idle(); d_req = 1'b1; d_addr = 17'(a); step(tag);
    endtask

    task automatic store(input int a, input string tag);
        idle(); d_req = 1'b1; d_we = 1'b1; d_addr = 17'(a); step(tag);
    endtask

    task automatic fetch(input int a, input string tag);
        idle(); i_req = 1'b1; i_addr = 17'(a); step(tag);
    endtask

    task automatic regwr(input int ra, input int v, input string tag);
        idle(); reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'(ra); reg_wdata = 32'(v); step(tag);
    endtask

    task automatic readfault(input string tag);
        idle(); reg_sel = 1'b1; reg_addr = 4'd0; step(tag);
    endtask

    function automatic int pick_addr();
        int sel;
        sel = $urandom_range(0, 2);
        if (sel == 0) return $urandom_range(0, 'h3FFF);
        if (sel == 1) return 'h10000 + ($urandom_range(0, 3) << 13) + ($urandom_range(0, 3) << 8)
                             + $urandom_range(0, 255);
        return $urandom_range(0, 'h1FFFF);
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) begin m_valid[k] = 0; m_tag[k] = 0; end
        m_pend = 1'b0; m_code = 0; m_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        readfault("R11");
        // untranslated traffic outside the window
        load('h00123, "R1");
        store('h01FFF, "R1");
        fetch('h18000, "R1");
        load('h0FFFF, "R1");
        // cold miss, capture, hold while pending, acknowledge
        load('h10345, "R5");
        readfault("R5");
        fetch('h11000, "R8");
        readfault("R8");
        regwr(3, 0, "R8");
        readfault("R8");
        // fill then hit on both ports, tag conflict on the same line
        regwr(1, 'h10345, "R9");
        load('h10345, "R3");
        fetch('h103FF, "R4");
        load('h12345, "R2");
        readfault("R2");
        regwr(3, 0, "R8");
        // fetch miss cause
        fetch('h17F00, "R6");
        readfault("R6");
        regwr(3, 0, "R8");
        // store into a resident line faults and keeps the line
        store('h10345, "R7");
        readfault("R7");
        regwr(3, 0, "R8");
        load('h10345, "R7");
        // simultaneous faults: data wins
        idle(); d_req = 1'b1; d_addr = 17'h14000; i_req = 1'b1; i_addr = 17'h15000; step("R12");
        readfault("R12");
        regwr(3, 0, "R8");
        // fill every line with the top tag, then flush
        for (int k = 0; k < 32; k++) regwr(1, 'h16000 + k * 256, "R9");
        fetch('h17FFF, "R2");
        load('h16000, "R3");
        regwr(2, 0, "R10");
        load('h16000, "R10");
        regwr(3, 0, "R8");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            idle();
            op = $urandom_range(0, 99);
            d_req = ($urandom_range(0, 1) == 1);
            d_we = ($urandom_range(0, 3) == 0);
            d_addr = 17'(pick_addr());
            i_req = ($urandom_range(0, 1) == 1);
            i_addr = 17'(pick_addr());
            reg_addr = 4'($urandom_range(0, 4));
            if (op < 15) begin
                reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'd1;
                reg_wdata = 32'('h10000 + ($urandom_range(0, 3) << 13) + ($urandom_range(0, 3) << 8));
            end else if (op < 30) begin
                reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'd3;
            end else if (op < 33) begin
                reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'd2;
            end
            step("R2");
        end
        idle();
        step("R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule